// File: doc/BRIEF.md
# MSI Cache Controller with Directory Messaging

This block keeps a small direct-mapped cache coherent under an MSI protocol in which a home directory, not a shared bus, orders every transaction. The processor presents loads and stores. Accesses that the local line state allows complete at once. Any other access turns into a request message to the directory, and the processor is stalled until the matching data reply comes back. The directory can also send messages of its own: an invalidate, which takes the line away, or a fetch, which pulls back dirty data while a reader joins. Each of these is answered with an acknowledgement, and the answer carries the word when the line was dirty.

Each line holds one data word, a tag and a two-bit state. At most one miss is outstanding at any time. A pending record keeps the address, the direction and the store data of that miss. Before the miss goes out, a conflicting victim line is written back if it is modified, or announced with a leave notice if it is shared. A negative acknowledgement makes the controller send the same request again. A reply for some other address, or one that arrives when nothing is outstanding, is dropped.

Top module: `msi_dir_cache`

## Requirements
- R1: A load to a line held shared (state 1) or modified (state 2), and a store to a modified line, finish in the cycle they are presented: cpu_stall is low and no outbound message follows. A load returns the stored word on cpu_rdata, and cpu_rdata is zero whenever no access completes.
- R2: A load that misses sends a read miss (out_type 0) carrying the request address on the next cycle. cpu_stall stays high until a data reply (in_type 2) with that address arrives. The line then becomes shared with the reply word, and the load completes on the following cycle.
- R3: A store that misses, or a store to a shared line, sends a write miss (out_type 1). After the data reply the line becomes modified and holds the store word, not the reply word.
- R4: An invalidate (in_type 0) for a line held shared is answered one cycle later with a plain acknowledgement (out_type 4, data zero), and the line becomes invalid.
- R5: An invalidate for a modified line is answered with a write-back reply (out_type 5) that carries the line's word, and the line becomes invalid.
- R6: A fetch (in_type 1) for a modified line is answered with out_type 5 carrying the word. The line becomes shared, so later loads still hit and stores miss.
- R7: A miss whose direct-mapped slot holds a modified line with a different tag first sends an eviction write-back (out_type 2) with the victim's address and word. The miss request follows on the next free cycle.
- R8: A miss whose slot holds a shared line with a different tag first sends a leave notice (out_type 3, victim address, data zero) when EVICT_NOTIFY is 1. The miss request follows on the next free cycle.
- R9: An invalidate or fetch for a line not held (invalid, or a different tag), and a fetch for a line held shared, get a plain acknowledgement (out_type 4) and change no line state.
- R10: A negative acknowledgement (in_type 3) whose address matches the outstanding miss makes the controller resend the same miss request on the next cycle, and it keeps waiting.
- R11: After reset, out_valid and cpu_stall are low. An inbound invalidate or fetch has priority over the processor: any access presented in that cycle stalls, and a queued miss request is held back. Every outbound message appears one cycle after the cycle that caused it.
- R12: A data reply or negative acknowledgement whose address differs from the outstanding miss, or that arrives with nothing outstanding, produces no message and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access present, held until stall drops |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store word |
| cpu_stall | output | 1 | Access not completed this cycle |
| cpu_rdata | output | DATA_W | Load word, valid when the access completes |
| in_valid | input | 1 | Directory message present |
| in_type | input | 2 | 0 invalidate, 1 fetch, 2 data reply, 3 negative acknowledgement |
| in_addr | input | ADDR_W | Line address of the directory message |
| in_data | input | DATA_W | Word carried by a data reply |
| out_valid | output | 1 | Outbound message present |
| out_type | output | 3 | 0 read miss, 1 write miss, 2 eviction write-back, 3 leave notice, 4 acknowledgement, 5 write-back reply |
| out_addr | output | ADDR_W | Line address of the outbound message |
| out_data | output | DATA_W | Word carried by types 2 and 5, zero otherwise |

## Verification
If a line state is wrong, the ports show it at the next access to that line. A load that should hit raises cpu_stall in the same cycle, a store that should miss finishes silently, and a snoop reply comes back one cycle later with the wrong type or with a missing word. If the pending record is wrong, the fault appears at the reply cycle: the wrong state or word is installed, or a resend or eviction message is misaddressed one cycle after its cause. The bench therefore compares the stall, the read word and the full outbound message against a behavioural model on every cycle, so a divergence is reported within one or two cycles of where it starts.

// File: rtl/msi_dc_pkg.sv
package msi_dc_pkg;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    IN_INV   = 2'd0,
    IN_FETCH = 2'd1,
    IN_DATA  = 2'd2,
    IN_NACK  = 2'd3
  } in_msg_e;

  typedef enum logic [2:0] {
    OUT_RDMISS = 3'd0,
    OUT_WRMISS = 3'd1,
    OUT_EVWB   = 3'd2,
    OUT_EVSH   = 3'd3,
    OUT_ACK    = 3'd4,
    OUT_ACKWB  = 3'd5
  } out_msg_e;

  // Access allowed locally without contacting the directory.
  function automatic logic access_hits(line_st_e st, logic wr, logic tag_eq);
    return tag_eq && (wr ? (st == LN_M) : (st != LN_I));
  endfunction

  // State entered when the data reply of a miss arrives.
  function automatic line_st_e fill_state(logic wr);
    return wr ? LN_M : LN_S;
  endfunction

  function automatic out_msg_e miss_code(logic wr);
    return wr ? OUT_WRMISS : OUT_RDMISS;
  endfunction

  // State after an invalidate or fetch hits a held line.
  function automatic line_st_e snoop_next(in_msg_e t, line_st_e st);
    if (t == IN_INV) return LN_I;
    if (st == LN_M) return LN_S;
    return st;
  endfunction

endpackage

// File: rtl/msi_dc_array.sv
module msi_dc_array #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [1:0]        w_st,
  input  logic [DATA_W-1:0] w_data,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [1:0]        ra_st,
  output logic [DATA_W-1:0] ra_data,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [1:0]        rb_st,
  output logic [DATA_W-1:0] rb_data
);
  localparam int NLINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q  [NLINES];
  logic [1:0]        st_q   [NLINES];
  logic [DATA_W-1:0] data_q [NLINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) st_q[i] <= 2'd0;
    end else if (we) begin
      st_q[w_idx] <= w_st;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[w_idx]  <= w_tag;
      data_q[w_idx] <= w_data;
    end
  end

  assign ra_tag  = tag_q[ra_idx];
  assign ra_st   = st_q[ra_idx];
  assign ra_data = data_q[ra_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_st   = st_q[rb_idx];
  assign rb_data = data_q[rb_idx];

endmodule

// File: rtl/msi_dc_responder.sv
module msi_dc_responder
  import msi_dc_pkg::*;
#(
  parameter int TAG_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              in_valid,
  input  logic [1:0]        in_type,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_e          line_st,
  input  logic [DATA_W-1:0] line_data,
  output logic              busy,
  output out_msg_e          rsp_type,
  output logic [DATA_W-1:0] rsp_data,
  output logic              upd,
  output line_st_e          upd_st,
  output logic              ev_stale
);
  in_msg_e kind;
  logic    held;
  logic    dirty;

  assign kind     = in_msg_e'(in_type);
  assign busy     = in_valid && (kind == IN_INV || kind == IN_FETCH);
  assign held     = (line_tag == in_tag) && (line_st != LN_I);
  assign dirty    = held && (line_st == LN_M);
  assign rsp_type = dirty ? OUT_ACKWB : OUT_ACK;
  assign rsp_data = dirty ? line_data : '0;
  assign upd      = busy && held && (kind == IN_INV || dirty);
  assign upd_st   = snoop_next(kind, line_st);
  assign ev_stale = busy && !held;

endmodule

// File: rtl/msi_dc_miss_fsm.sv
module msi_dc_miss_fsm
  import msi_dc_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int IDX_W        = 3,
  parameter int DATA_W       = 16,
  parameter bit EVICT_NOTIFY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss,
  input  logic              hold,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [ADDR_W-IDX_W-1:0] a_tag,
  input  line_st_e          a_st,
  input  logic [DATA_W-1:0] a_data,
  input  logic              in_valid,
  input  logic [1:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              idle,
  output logic              pending,
  output logic              msg_fire,
  output out_msg_e          msg_type,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data,
  output logic              arr_we,
  output logic [IDX_W-1:0]  arr_idx,
  output logic [ADDR_W-IDX_W-1:0] arr_tag,
  output line_st_e          arr_st,
  output logic [DATA_W-1:0] arr_data,
  output logic              ev_reissue
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} fsm_e;

  fsm_e              fs_q, fs_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic              pw_q, pw_d;
  logic [DATA_W-1:0] pd_q, pd_d;

  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              reply_match;

  assign req_idx     = cpu_addr[IDX_W-1:0];
  assign req_tag     = cpu_addr[ADDR_W-1:IDX_W];
  assign reply_match = in_valid && (in_addr == pa_q);
  assign idle        = (fs_q == F_IDLE);
  assign pending     = (fs_q != F_IDLE);

  always_comb begin
    fs_d       = fs_q;
    pa_d       = pa_q;
    pw_d       = pw_q;
    pd_d       = pd_q;
    msg_fire   = 1'b0;
    msg_type   = OUT_RDMISS;
    msg_addr   = pa_q;
    msg_data   = '0;
    arr_we     = 1'b0;
    arr_idx    = req_idx;
    arr_tag    = a_tag;
    arr_st     = a_st;
    arr_data   = a_data;
    ev_reissue = 1'b0;
    case (fs_q)
      F_IDLE: begin
        if (miss && !hold) begin
          pa_d     = cpu_addr;
          pw_d     = cpu_write;
          pd_d     = cpu_wdata;
          msg_fire = 1'b1;
          if (a_st != LN_I && a_tag != req_tag) begin
            arr_we   = 1'b1;
            arr_st   = LN_I;
            msg_addr = {a_tag, req_idx};
            if (a_st == LN_M) begin
              msg_type = OUT_EVWB;
              msg_data = a_data;
              fs_d     = F_ISSUE;
            end else if (EVICT_NOTIFY) begin
              msg_type = OUT_EVSH;
              fs_d     = F_ISSUE;
            end else begin
              msg_type = miss_code(cpu_write);
              msg_addr = cpu_addr;
              fs_d     = F_WAIT;
            end
          end else begin
            msg_type = miss_code(cpu_write);
            msg_addr = cpu_addr;
            fs_d     = F_WAIT;
          end
        end
      end
      F_ISSUE: begin
        if (!hold) begin
          msg_fire = 1'b1;
          msg_type = miss_code(pw_q);
          fs_d     = F_WAIT;
        end
      end
      default: begin
        if (reply_match && in_msg_e'(in_type) == IN_DATA) begin
          arr_we   = 1'b1;
          arr_idx  = pa_q[IDX_W-1:0];
          arr_tag  = pa_q[ADDR_W-1:IDX_W];
          arr_st   = fill_state(pw_q);
          arr_data = pw_q ? pd_q : in_data;
          fs_d     = F_IDLE;
        end else if (reply_match && in_msg_e'(in_type) == IN_NACK) begin
          msg_fire   = 1'b1;
          msg_type   = miss_code(pw_q);
          ev_reissue = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q <= F_IDLE;
      pa_q <= '0;
      pw_q <= 1'b0;
      pd_q <= '0;
    end else begin
      fs_q <= fs_d;
      pa_q <= pa_d;
      pw_q <= pw_d;
      pd_q <= pd_d;
    end
  end

endmodule

// File: rtl/msi_dir_cache.sv
module msi_dir_cache
  import msi_dc_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int IDX_W        = 3,
  parameter int DATA_W       = 16,
  parameter bit EVICT_NOTIFY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              in_valid,
  input  logic [1:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [2:0]        out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  c_idx, m_idx;
  logic [TAG_W-1:0]  c_tag, m_tag;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [1:0]        a_st_raw, b_st_raw;
  line_st_e          a_st, b_st;
  logic [DATA_W-1:0] a_data, b_data;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign m_idx = in_addr[IDX_W-1:0];
  assign m_tag = in_addr[ADDR_W-1:IDX_W];
  assign a_st  = line_st_e'(a_st_raw);
  assign b_st  = line_st_e'(b_st_raw);

  // Named internal events used by the bound checker.
  logic     snoop_busy, ev_stale, ev_reissue, hit_ok, hit_cond, fsm_pending, fsm_idle;
  out_msg_e rsp_type;
  logic [DATA_W-1:0] rsp_data;
  logic     rsp_upd;
  line_st_e rsp_st;

  logic              f_fire, f_we;
  out_msg_e          f_type;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data, f_wdata;
  logic [IDX_W-1:0]  f_idx;
  logic [TAG_W-1:0]  f_tag;
  line_st_e          f_st;

  logic              w_we;
  logic [IDX_W-1:0]  w_idx;
  logic [TAG_W-1:0]  w_tag;
  line_st_e          w_st;
  logic [DATA_W-1:0] w_data;

  msi_dc_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(c_idx), .rb_idx(m_idx),
    .we(w_we), .w_idx(w_idx), .w_tag(w_tag), .w_st(w_st), .w_data(w_data),
    .ra_tag(a_tag), .ra_st(a_st_raw), .ra_data(a_data),
    .rb_tag(b_tag), .rb_st(b_st_raw), .rb_data(b_data)
  );

  msi_dc_responder #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_resp (
    .in_valid(in_valid), .in_type(in_type), .in_tag(m_tag),
    .line_tag(b_tag), .line_st(b_st), .line_data(b_data),
    .busy(snoop_busy), .rsp_type(rsp_type), .rsp_data(rsp_data),
    .upd(rsp_upd), .upd_st(rsp_st), .ev_stale(ev_stale)
  );

  assign hit_cond = access_hits(a_st, cpu_write, a_tag == c_tag);
  assign hit_ok   = cpu_valid && fsm_idle && !snoop_busy && hit_cond;

  msi_dc_miss_fsm #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .EVICT_NOTIFY(EVICT_NOTIFY)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .miss(cpu_valid && !hit_cond), .hold(snoop_busy),
    .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
    .in_valid(in_valid), .in_type(in_type), .in_addr(in_addr), .in_data(in_data),
    .idle(fsm_idle), .pending(fsm_pending),
    .msg_fire(f_fire), .msg_type(f_type), .msg_addr(f_addr), .msg_data(f_data),
    .arr_we(f_we), .arr_idx(f_idx), .arr_tag(f_tag), .arr_st(f_st), .arr_data(f_wdata),
    .ev_reissue(ev_reissue)
  );

  // Single array write port: snoop update, then miss engine, then store hit.
  always_comb begin
    w_we   = 1'b0;
    w_idx  = c_idx;
    w_tag  = a_tag;
    w_st   = a_st;
    w_data = a_data;
    if (rsp_upd) begin
      w_we   = 1'b1;
      w_idx  = m_idx;
      w_tag  = b_tag;
      w_st   = rsp_st;
      w_data = b_data;
    end else if (f_we) begin
      w_we   = 1'b1;
      w_idx  = f_idx;
      w_tag  = f_tag;
      w_st   = f_st;
      w_data = f_wdata;
    end else if (hit_ok && cpu_write) begin
      w_we   = 1'b1;
      w_st   = LN_M;
      w_data = cpu_wdata;
    end
  end

  assign cpu_stall = cpu_valid && !hit_ok;
  assign cpu_rdata = hit_ok ? a_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_type  <= 3'd0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (snoop_busy) begin
      out_valid <= 1'b1;
      out_type  <= rsp_type;
      out_addr  <= in_addr;
      out_data  <= rsp_data;
    end else if (f_fire) begin
      out_valid <= 1'b1;
      out_type  <= f_type;
      out_addr  <= f_addr;
      out_data  <= f_data;
    end else begin
      out_valid <= 1'b0;
      out_type  <= 3'd0;
      out_addr  <= '0;
      out_data  <= '0;
    end
  end

endmodule

// File: rtl/msi_dir_cache_chk.sv
module msi_dir_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_valid,
  input logic       cpu_stall,
  input logic       out_valid,
  input logic [2:0] out_type,
  input logic       hit_ok,
  input logic       snoop_busy,
  input logic       ev_stale,
  input logic       ev_reissue,
  input logic       pending
);

  AST_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ok |=> !out_valid); // R1

  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pending && cpu_valid |-> cpu_stall); // R2

  AST_SNOOP_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_busy |=> out_valid && (out_type == 3'd4 || out_type == 3'd5)); // R11

  AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_busy && cpu_valid |-> cpu_stall); // R11

  AST_STALE_PLAIN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stale |=> out_valid && out_type == 3'd4); // R9

  AST_NACK_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reissue |=> out_valid && (out_type == 3'd0 || out_type == 3'd1)); // R10

endmodule

bind msi_dir_cache msi_dir_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_stall(cpu_stall),
  .out_valid(out_valid), .out_type(out_type), .hit_ok(hit_ok),
  .snoop_busy(snoop_busy), .ev_stale(ev_stale), .ev_reissue(ev_reissue),
  .pending(fsm_pending)
);

// File: tb/msi_dir_cache_test.sv
module msi_dir_cache_test;
  localparam int NL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 0, cpu_write = 0;
  logic [11:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        in_valid = 0;
  logic [1:0]  in_type = '0;
  logic [11:0] in_addr = '0;
  logic [15:0] in_data = '0;
  logic        cpu_stall, out_valid;
  logic [15:0] cpu_rdata, out_data;
  logic [2:0]  out_type;
  logic [11:0] out_addr;

  int checks = 0, fails = 0, cyc = 0;

  // Behavioural model state: 0 invalid, 1 shared, 2 modified.
  int m_tag[NL], m_st[NL], m_data[NL];
  int mode = 0;  // 0 free, 1 request queued behind eviction, 2 awaiting reply
  int p_addr = 0, p_wr = 0, p_wd = 0;
  int e_stall, e_rd, e_ov, e_ot, e_oa, e_od;
  string why_cpu, why_out;

  always #4 clk = ~clk;

  msi_dir_cache #(.ADDR_W(12), .IDX_W(3), .DATA_W(16), .EVICT_NOTIFY(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
    .cpu_rdata(cpu_rdata), .in_valid(in_valid), .in_type(in_type),
    .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid),
    .out_type(out_type), .out_addr(out_addr), .out_data(out_data)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL R11 watchdog expired: actual running expected finished");
      finish_run();
    end
  end

  task automatic model_eval();
    int ci, ct, mi, mt;
    bit snoop, hitable, hit, held;
    ci = cpu_addr % NL; ct = cpu_addr / NL;
    mi = in_addr % NL;  mt = in_addr / NL;
    snoop   = in_valid && (in_type == 0 || in_type == 1);
    hitable = (m_tag[ci] == ct) && (cpu_write ? m_st[ci] == 2 : m_st[ci] != 0);
    hit     = (mode == 0) && !snoop && cpu_valid && hitable;
    e_stall = cpu_valid && !hit;
    e_rd    = hit ? m_data[ci] : 0;
    why_cpu = hit ? "R1" : (mode != 0 ? "R2" : (snoop ? "R11" : (cpu_write ? "R3" : "R2")));
    e_ov = 0; e_ot = 0; e_oa = 0; e_od = 0; why_out = "R12";
    if (snoop) begin
      held = (m_tag[mi] == mt) && m_st[mi] != 0;
      e_ov = 1; e_oa = in_addr; e_ot = 4;
      if (held && m_st[mi] == 2) begin
        e_ot = 5; e_od = m_data[mi];
        why_out = (in_type == 0) ? "R5" : "R6";
        m_st[mi] = (in_type == 0) ? 0 : 1;
      end else if (held) begin
        why_out = (in_type == 0) ? "R4" : "R9";
        if (in_type == 0) m_st[mi] = 0;
      end else why_out = "R9";
    end else if (mode == 0) begin
      if (cpu_valid && !hitable) begin
        p_addr = cpu_addr; p_wr = cpu_write; p_wd = cpu_wdata; e_ov = 1;
        if (m_st[ci] != 0 && m_tag[ci] != ct) begin
          e_oa = m_tag[ci] * NL + ci;
          if (m_st[ci] == 2) begin e_ot = 2; e_od = m_data[ci]; why_out = "R7"; end
          else begin e_ot = 3; why_out = "R8"; end
          m_st[ci] = 0; mode = 1;
        end else begin
          e_ot = cpu_write; e_oa = cpu_addr; mode = 2;
          why_out = cpu_write ? "R3" : "R2";
        end
      end else if (hit && cpu_write) m_data[ci] = cpu_wdata;
    end else if (mode == 1) begin
      e_ov = 1; e_ot = p_wr; e_oa = p_addr; why_out = "R7"; mode = 2;
    end else if (in_valid && in_addr == p_addr) begin
      if (in_type == 2) begin
        m_tag[p_addr % NL]  = p_addr / NL;
        m_st[p_addr % NL]   = p_wr ? 2 : 1;
        m_data[p_addr % NL] = p_wr ? p_wd : in_data;
        mode = 0;
      end else if (in_type == 3) begin
        e_ov = 1; e_ot = p_wr; e_oa = p_addr; why_out = "R10";
      end
    end
  endtask

  task automatic step();
    #2;
    model_eval();
    checks++;
    if (cpu_stall !== e_stall[0] || int'(cpu_rdata) != e_rd) begin
      fails++;
      $display("FAIL %s cpu side: actual stall=%0b rdata=%h expected stall=%0d rdata=%h",
               why_cpu, cpu_stall, cpu_rdata, e_stall, e_rd);
    end
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== e_ov[0] ||
        (e_ov != 0 && (int'(out_type) != e_ot || int'(out_addr) != e_oa || int'(out_data) != e_od))) begin
      fails++;
      $display("FAIL %s message: actual v=%0b t=%0d a=%h d=%h expected v=%0d t=%0d a=%h d=%h",
               why_out, out_valid, out_type, out_addr, out_data, e_ov, e_ot, e_oa, e_od);
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cpu(bit v, bit w, logic [11:0] a, logic [15:0] d);
    cpu_valid = v; cpu_write = w; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic msg(bit v, logic [1:0] t, logic [11:0] a, logic [15:0] d);
    in_valid = v; in_type = t; in_addr = a; in_data = d;
  endtask

  // Reply to the outstanding miss, then let the held access complete.
  task automatic reply(logic [11:0] a, logic [15:0] d);
    msg(1, 2, a, d); step();
    msg(0, 0, 0, 0); step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    checks++;
    if (out_valid !== 1'b0 || cpu_stall !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: actual out_valid=%0b stall=%0b expected 0 0", out_valid, cpu_stall);
    end
    steps(2);
    // R2: load miss, wait, reply, then hit
    cpu(1, 0, 12'h010, 0); steps(3); reply(12'h010, 16'hA5A5);
    cpu(0, 0, 0, 0); step();
    // R10 and R12: resend on NACK, ignore mismatched replies
    cpu(1, 0, 12'h021, 0); steps(2);
    msg(1, 3, 12'h021, 0); step();
    msg(1, 3, 12'h555, 0); step();
    msg(1, 2, 12'h777, 16'h9999); step();
    reply(12'h021, 16'h1111);
    cpu(0, 0, 0, 0); step();
    msg(1, 2, 12'h010, 16'h4444); step(); msg(0, 0, 0, 0); step();
    // R3: upgrade a shared line, store word wins over reply word
    cpu(1, 1, 12'h010, 16'hBEEF); steps(2); reply(12'h010, 16'hFFFF);
    cpu(1, 0, 12'h010, 0); step();
    // R4: invalidate a shared line, then it misses again
    cpu(0, 0, 0, 0); msg(1, 0, 12'h021, 0); step(); msg(0, 0, 0, 0);
    cpu(1, 0, 12'h021, 0); steps(2); reply(12'h021, 16'h2121);
    // R6: fetch of modified line, later load hits and store misses
    cpu(0, 0, 0, 0); msg(1, 1, 12'h010, 0); step(); msg(0, 0, 0, 0);
    cpu(1, 0, 12'h010, 0); step();
    cpu(1, 1, 12'h010, 16'h0F0F); steps(2);
    // R9 fetch on shared line while the upgrade is waiting
    msg(1, 1, 12'h010, 0); step(); msg(0, 0, 0, 0);
    reply(12'h010, 16'h0000);
    // R5: invalidate modified line
    cpu(0, 0, 0, 0); msg(1, 0, 12'h010, 0); step();
    // R9: stale snoops
    msg(1, 0, 12'h300, 0); step();
    msg(1, 1, 12'h010, 0); step();
    msg(0, 0, 0, 0);
    cpu(1, 0, 12'h010, 0); steps(2); reply(12'h010, 16'h3030);
    // R7: dirty victim eviction before the miss
    cpu(1, 1, 12'h022, 16'h2222); steps(2); reply(12'h022, 16'h0000);
    cpu(1, 0, 12'h042, 0); steps(3); reply(12'h042, 16'h4242);
    // R8: shared victim leave notice before the miss
    cpu(1, 0, 12'h023, 0); steps(2); reply(12'h023, 16'h2323);
    cpu(1, 0, 12'h063, 0); steps(3); reply(12'h063, 16'h6363);
    // R11: snoop beats a store hit in the same cycle
    cpu(1, 1, 12'h044, 16'h4444); steps(2); reply(12'h044, 16'h0000);
    cpu(1, 1, 12'h044, 16'h5555); msg(1, 0, 12'h025, 0); step();
    msg(0, 0, 0, 0); step();
    // R11: snoop holds back the queued miss behind an eviction
    cpu(1, 1, 12'h064, 16'h6464); step();
    msg(1, 0, 12'h100, 0); step(); msg(0, 0, 0, 0);
    steps(2); reply(12'h064, 16'h0000);
    cpu(1, 0, 12'h064, 0); step();
    cpu(0, 0, 0, 0); steps(2);
    finish_run();
  end

endmodule